// File: doc/BRIEF.md
# Bidirectional recirculating shift register

A serial storage chain of 32 single-bit stages. On every rising clock edge it moves its contents one place toward the high end or toward the low end, as a direction input selects. The stage left empty at the entry end is filled from one of two sources. It can take a dedicated serial input for that direction, or, in rotate mode, the bit leaving the far end, which turns the chain into a rotator. A freeze input holds every stage for that edge.

Each end stage drives a serial output through its own flip-flop, and that flip-flop is loaded on the falling clock edge. Because the new value shows up half a cycle after the shift, two copies on one clock can be chained end to end into a longer register with no race between them. Pushing and popping at one end gives a last-in first-out stack. Entering at one end and leaving at the other gives a first-in first-out delay line. A read-only debug bus shows every stage. Its bit 0 is stage 1 and its bit 31 is stage 32.

Top module: `bidir_rotor`

## Requirements
- R1: A high `rst` sampled at a rising edge clears all stages. A high `rst` at a falling edge clears both serial outputs. Reset wins over `freeze`.
- R2: With `go_left`=0, `take_ext`=1 and `freeze`=0, a rising edge loads `right_in` into stage 1 (`stages[0]`), and each stage k gets the old stage k-1.
- R3: With `go_left`=1, `take_ext`=1 and `freeze`=0, a rising edge loads `left_in` into stage 32 (`stages[31]`), and each stage k gets the old stage k+1.
- R4: With `go_left`=0, `take_ext`=0 and `freeze`=0, a rising edge loads stage 1 from the old stage 32, so the chain rotates toward the high end. `right_in` and `left_in` have no effect.
- R5: With `go_left`=1, `take_ext`=0 and `freeze`=0, a rising edge loads stage 32 from the old stage 1, so the chain rotates toward the low end. Both serial inputs have no effect.
- R6: With `freeze`=1 and `rst`=0, no stage changes at a rising edge, whatever `go_left`, `take_ext` and the serial inputs are.
- R7: `left_out` is loaded with stage 1 and `right_out` with stage 32 at each falling edge. Both stay unchanged through the high phase that follows.
- R8: Two instances on one clock act as one 64-stage register in either direction. For this, `right_out` of the first feeds `right_in` of the second, and `left_out` of the second feeds `left_in` of the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; stages shift on the rising edge, outputs load on the falling edge |
| rst | input | 1 | Synchronous active-high clear |
| go_left | input | 1 | 0: move toward stage 32; 1: move toward stage 1 |
| take_ext | input | 1 | 1: fill from the serial input; 0: rotate |
| freeze | input | 1 | 1: hold all stages |
| right_in | input | 1 | Serial input entering stage 1 |
| left_in | input | 1 | Serial input entering stage 32 |
| left_out | output | 1 | Stage 1, registered on the falling edge |
| right_out | output | 1 | Stage 32, registered on the falling edge |
| stages | output | 32 | Debug view of all stages, bit 0 = stage 1 |

## Verification
The assertions check four things at every rising edge: freeze holds the stages, each of the four shift modes places the right bit at each end, and reset clears the array. They also check that each serial output matches its end stage from the preceding falling edge. Only the bench scenarios can show that the whole array follows a reference model across long runs of mixed control settings. The same holds for reset beating freeze and for the serial inputs being ignored while rotating. Two chained copies acting as one 64-stage register in both directions is also shown only by the bench.

// File: rtl/bidir_rotor.sv
module bidir_rotor #(
  parameter int STAGES = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go_left,
  input  logic              take_ext,
  input  logic              freeze,
  input  logic              right_in,
  input  logic              left_in,
  output logic              left_out,
  output logic              right_out,
  output logic [STAGES-1:0] stages
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] q;
  logic [STAGES-1:0] nxt;
  logic fill_low;
  logic fill_high;

  assign fill_low  = take_ext ? right_in : q[LAST];
  assign fill_high = take_ext ? left_in  : q[0];

  generate
    for (genvar k = 0; k < STAGES; k++) begin : g_stage
      logic from_below;
      logic from_above;
      if (k == 0) begin : g_first
        assign from_below = fill_low;
      end else begin : g_mid_lo
        assign from_below = q[k-1];
      end
      if (k == LAST) begin : g_last
        assign from_above = fill_high;
      end else begin : g_mid_hi
        assign from_above = q[k+1];
      end
      assign nxt[k] = go_left ? from_above : from_below;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)          q <= '0;
    else if (!freeze) q <= nxt;
  end

  always_ff @(negedge clk) begin
    if (rst) begin
      left_out  <= 1'b0;
      right_out <= 1'b0;
    end else begin
      left_out  <= q[0];
      right_out <= q[LAST];
    end
  end

  assign stages = q;

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (stages == '0));

  assert_freeze_hold_R6: assert property (@(posedge clk) disable iff (rst)
    freeze |=> $stable(stages));

  assert_ext_right_R2: assert property (@(posedge clk) disable iff (rst)
    (!freeze && !go_left && take_ext) |=>
      (stages[0] == $past(right_in)) && (stages[LAST:1] == $past(stages[LAST-1:0])));

  assert_ext_left_R3: assert property (@(posedge clk) disable iff (rst)
    (!freeze && go_left && take_ext) |=>
      (stages[LAST] == $past(left_in)) && (stages[LAST-1:0] == $past(stages[LAST:1])));

  assert_rot_right_R4: assert property (@(posedge clk) disable iff (rst)
    (!freeze && !go_left && !take_ext) |=> (stages[0] == $past(stages[LAST])));

  assert_rot_left_R5: assert property (@(posedge clk) disable iff (rst)
    (!freeze && go_left && !take_ext) |=> (stages[LAST] == $past(stages[0])));

  assert_out_track_R7: assert property (@(posedge clk) disable iff (rst)
    (left_out == stages[0]) && (right_out == stages[LAST]));
endmodule

// File: tb/bidir_rotor_test.sv
module bidir_rotor_test;
  logic clk = 1'b0;
  logic rst, go_left, take_ext, freeze, right_in, left_in2;
  logic lo1, ro1, lo2, ro2;
  logic [31:0] st1, st2;
  logic [31:0] m1, m2;
  logic mo1l, mo1r, mo2l, mo2r;
  logic [15:0] lfsr = 16'hACE1;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  bidir_rotor #(.STAGES(32)) uut (
    .clk(clk), .rst(rst), .go_left(go_left), .take_ext(take_ext), .freeze(freeze),
    .right_in(right_in), .left_in(lo2), .left_out(lo1), .right_out(ro1), .stages(st1));

  bidir_rotor #(.STAGES(32)) uut2 (
    .clk(clk), .rst(rst), .go_left(go_left), .take_ext(take_ext), .freeze(freeze),
    .right_in(ro1), .left_in(left_in2), .left_out(lo2), .right_out(ro2), .stages(st2));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] step(input logic [31:0] m, input logic l, input logic e,
                                       input logic f, input logic ri, input logic li);
    if (f) return m;
    if (!l) return {m[30:0], e ? ri : m[31]};
    return {e ? li : m[0], m[31:1]};
  endfunction

  function automatic string tag(input logic l, input logic e, input logic f);
    if (f) return "R6";
    if (!l) return e ? "R2/R8" : "R4";
    return e ? "R3/R8" : "R5";
  endfunction

  task automatic cyc(input logic l, input logic e, input logic f);
    logic [31:0] n1, n2;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    go_left = l; take_ext = e; freeze = f;
    right_in = lfsr[0]; left_in2 = lfsr[5];
    n1 = step(m1, l, e, f, right_in, mo2l);
    n2 = step(m2, l, e, f, mo1r, left_in2);
    @(posedge clk); #5;
    m1 = n1; m2 = n2;
    chk(st1 == m1, tag(l, e, f), {32'h0, st1}, {32'h0, m1});
    chk(st2 == m2, tag(l, e, f), {32'h0, st2}, {32'h0, m2});
    chk({lo1, ro1, lo2, ro2} == {mo1l, mo1r, mo2l, mo2r}, "R7 high phase",
        {60'h0, lo1, ro1, lo2, ro2}, {60'h0, mo1l, mo1r, mo2l, mo2r});
    @(negedge clk); #5;
    mo1l = m1[0]; mo1r = m1[31]; mo2l = m2[0]; mo2r = m2[31];
    chk({lo1, ro1, lo2, ro2} == {mo1l, mo1r, mo2l, mo2r}, "R7 falling edge",
        {60'h0, lo1, ro1, lo2, ro2}, {60'h0, mo1l, mo1r, mo2l, mo2r});
  endtask

  task automatic do_reset(input logic f);
    rst = 1'b1; freeze = f;
    @(posedge clk); @(negedge clk); #5;
    rst = 1'b0;
    m1 = '0; m2 = '0; mo1l = 0; mo1r = 0; mo2l = 0; mo2r = 0;
    chk(st1 == 0 && st2 == 0, "R1 stages", {st2, st1}, 64'h0);
    chk({lo1, ro1, lo2, ro2} == 4'b0, "R1 outputs", {60'h0, lo1, ro1, lo2, ro2}, 64'h0);
  endtask

  initial begin
    rst = 1'b1; go_left = 0; take_ext = 1; freeze = 0; right_in = 0; left_in2 = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); #5;
    do_reset(1'b0);
    for (int i = 0; i < 80; i++) cyc(1'b0, 1'b1, 1'b0);
    for (int i = 0; i < 80; i++) cyc(1'b1, 1'b1, 1'b0);
    for (int i = 0; i < 70; i++) cyc(1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 70; i++) cyc(1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 8; i++) cyc(i[0], i[1], 1'b1);
    for (int r = 0; r < 6; r++)
      for (int c = 0; c < 8; c++)
        for (int j = 0; j < 10; j++) cyc(c[0], c[1], c[2]);
    for (int i = 0; i < 20; i++) cyc(1'b0, 1'b1, 1'b0);
    do_reset(1'b1);
    for (int i = 0; i < 10; i++) cyc(1'b1, 1'b1, 1'b0);
    done = 1;
  end

  initial begin
    int n = 0;
    while (!done && n < 100000) begin
      @(posedge clk);
      n++;
    end
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule